// File: doc/BRIEF.md
# B2 Error-Rate Defect Integrator

This block watches the count of line parity (B2) errors reported once per frame and turns it into a bit-error-rate defect level. Errors are summed over windows of a programmable number of frames. A window whose sum meets a threshold is a failing window. The defect is declared only after a programmable run of consecutive failing windows. Once the defect is active it is cleared by the same kind of integration. The clear side has its own window length, run length and threshold, so the hysteresis between declaring and clearing can be set freely. This lets the block ride through bursty error patterns without chattering.

Two copies of the integrator run side by side on the same error stream. One uses the excessive-error settings and the other the degraded-signal settings. The excessive-error defect can be routed, each under its own enable, to three action requests: AIS insertion, signal fault and remote defect indication. A single interrupt pulse marks every change of either defect.

Top module: `b2_rate_defect_mon`

## Requirements
- R1: After a synchronous reset, both defect outputs, the change interrupt and all three action requests are low.
- R2: A window spans the programmed number of frame strobes. It counts as failing on the declare side when its summed error count is greater than or equal to the declare threshold, so a sum exactly equal to the threshold fails.
- R3: An inactive defect is declared when the declare-side run count of consecutive failing windows is reached. The defect output is high from the second clock edge after the strobe of the last frame of that window.
- R4: A declare-side window below the threshold resets the run of failing windows to zero.
- R5: An active defect clears after the clear-side run count of consecutive clear windows. A clear window has a sum strictly below the clear threshold, which is independent of the declare threshold. A clear-side window at or above the clear threshold resets that run. Both window sequences restart at every defect change.
- R6: A change to window size, run count or threshold takes effect only at the next window boundary of that side. The current window is judged with the values it started with.
- R7: A programmed window size or run count of zero acts as one.
- R8: The change interrupt is high for exactly one clock cycle for each transition of either defect.
- R9: The three action requests follow the excessive-error defect, each gated by its own enable input. The enables act combinationally.
- R10: The two instances are independent. The degraded-signal defect never drives the action requests and never disturbs the excessive-error defect.
- R11: The per-window error sum saturates at 2^ACC_W-1 and does not wrap, so a long window of heavy errors still fails against the largest threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| b2_err | input | ERR_W | B2 error count of the frame, valid with frame_stb |
| exc_set_winsz | input | WIN_W | Excessive: declare window size in frames |
| exc_set_nwin | input | CNT_W | Excessive: consecutive failing windows to declare |
| exc_set_thr | input | ACC_W | Excessive: declare error threshold per window |
| exc_clr_winsz | input | WIN_W | Excessive: clear window size in frames |
| exc_clr_nwin | input | CNT_W | Excessive: consecutive clear windows to clear |
| exc_clr_thr | input | ACC_W | Excessive: clear error threshold per window |
| deg_set_winsz | input | WIN_W | Degraded: declare window size in frames |
| deg_set_nwin | input | CNT_W | Degraded: consecutive failing windows to declare |
| deg_set_thr | input | ACC_W | Degraded: declare error threshold per window |
| deg_clr_winsz | input | WIN_W | Degraded: clear window size in frames |
| deg_clr_nwin | input | CNT_W | Degraded: consecutive clear windows to clear |
| deg_clr_thr | input | ACC_W | Degraded: clear error threshold per window |
| en_ais | input | 1 | Route excessive defect to the AIS request |
| en_sf | input | 1 | Route excessive defect to the signal-fault request |
| en_rdi | input | 1 | Route excessive defect to the RDI request |
| exc_defect | output | 1 | Excessive-error defect level |
| deg_defect | output | 1 | Degraded-signal defect level |
| chg_irq | output | 1 | One-cycle pulse on any defect change |
| req_ais | output | 1 | AIS insertion request |
| req_sf | output | 1 | Signal-fault request |
| req_rdi | output | 1 | RDI request |

## Verification
A wrong window sum, window index or run count stays hidden until the window boundary it corrupts. It then shows as a defect edge one window too early or too late, or as a missing or extra interrupt pulse, two clock edges after the strobe of the last frame. The directed sequences are built so that each run-reset, boundary-latched setting, threshold equality and saturation case moves the defect edge by at least one whole window. Checking the defect level right after each window therefore exposes the fault within that window. A stuck or stretched interrupt shows up as an extra counted pulse in the very next check.

// File: rtl/b2i_pkg.sv
package b2i_pkg;

   // result of one closed window, valid for one cycle
   typedef struct packed {
      logic done;   // a window boundary was reached
      logic over;   // window sum >= threshold in force for that window
   } win_res_t;

   localparam int unsigned NUM_LVL = 2;   // excessive and degraded
   localparam int unsigned LVL_EXC = 0;
   localparam int unsigned LVL_DEG = 1;

endpackage

// File: rtl/b2i_window_acc.sv
module b2i_window_acc
   import b2i_pkg::*;
#(
   parameter int unsigned ERR_W = 16,
   parameter int unsigned ACC_W = 24,
   parameter int unsigned WIN_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic             frame_stb,
   input  logic [ERR_W-1:0] err,
   input  logic [WIN_W-1:0] cfg_winsz,
   input  logic [ACC_W-1:0] cfg_thr,
   output win_res_t         res
);

   localparam logic [ACC_W-1:0] ACC_MAX = '1;
   localparam logic [WIN_W-1:0] ONE_W   = WIN_W'(1);
   localparam int unsigned      PAD_W   = ACC_W + 1 - ERR_W;

   if (ACC_W < ERR_W) begin : g_chk_acc
      $error("b2i_window_acc: ACC_W must be at least ERR_W");
   end
   if (WIN_W < 1) begin : g_chk_win
      $error("b2i_window_acc: WIN_W must be at least 1");
   end

   logic [WIN_W-1:0] winsz_q;
   logic [WIN_W-1:0] idx_q;
   logic [ACC_W-1:0] thr_q;
   logic [ACC_W-1:0] sum_q;
   logic [ACC_W:0]   sum_wide;
   logic [ACC_W-1:0] sum_sat;
   logic             last_frame;

   always_comb begin
      sum_wide   = {1'b0, sum_q} + {{PAD_W{1'b0}}, err};
      sum_sat    = sum_wide[ACC_W] ? ACC_MAX : sum_wide[ACC_W-1:0];
      last_frame = (winsz_q == '0) || (idx_q >= (winsz_q - ONE_W));
   end

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         idx_q   <= '0;
         sum_q   <= '0;
         winsz_q <= cfg_winsz;
         thr_q   <= cfg_thr;
         res     <= '0;
      end else begin
         res.done <= 1'b0;
         res.over <= 1'b0;
         if (frame_stb) begin
            if (last_frame) begin
               res.done <= 1'b1;
               res.over <= (sum_sat >= thr_q);
               idx_q    <= '0;
               sum_q    <= '0;
               winsz_q  <= cfg_winsz;
               thr_q    <= cfg_thr;
            end else begin
               idx_q <= idx_q + ONE_W;
               sum_q <= sum_sat;
            end
         end
      end
   end

   // a window can only close on a frame strobe
   assert_done_after_stb_R2 : assert property (@(posedge clk) disable iff (rst)
      res.done |-> $past(frame_stb));

   // saturated sum never falls when an error frame is added mid-window
   assert_sum_no_wrap_R11 : assert property (@(posedge clk) disable iff (rst || restart)
      (frame_stb && !last_frame) |=> (sum_q >= $past(sum_q)));

endmodule

// File: rtl/b2i_run_cnt.sv
module b2i_run_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic             arm,
   input  logic             step,
   input  logic             qual,
   input  logic [CNT_W-1:0] cfg_nwin,
   output logic             fire
);

   if (CNT_W < 1) begin : g_chk_cnt
      $error("b2i_run_cnt: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] nwin_q;
   logic [CNT_W:0]   cnt_nxt;
   logic [CNT_W:0]   target;

   always_comb begin
      cnt_nxt = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
      target  = (nwin_q == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, nwin_q};
      fire    = arm && step && qual && (cnt_nxt >= target);
   end

   always_ff @(posedge clk) begin
      if (rst || restart || !arm) begin
         cnt_q  <= '0;
         nwin_q <= cfg_nwin;
      end else if (step) begin
         nwin_q <= cfg_nwin;
         if (qual && !fire) cnt_q <= cnt_nxt[CNT_W-1:0];
         else               cnt_q <= '0;
      end
   end

   // a non-qualifying window breaks the run
   assert_run_reset_R4 : assert property (@(posedge clk) disable iff (rst)
      (arm && step && !qual) |=> (cnt_q == '0));

endmodule

// File: rtl/b2i_integrator.sv
module b2i_integrator
   import b2i_pkg::*;
#(
   parameter int unsigned ERR_W = 16,
   parameter int unsigned ACC_W = 24,
   parameter int unsigned WIN_W = 16,
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             frame_stb,
   input  logic [ERR_W-1:0] err,
   input  logic [WIN_W-1:0] set_winsz,
   input  logic [CNT_W-1:0] set_nwin,
   input  logic [ACC_W-1:0] set_thr,
   input  logic [WIN_W-1:0] clr_winsz,
   input  logic [CNT_W-1:0] clr_nwin,
   input  logic [ACC_W-1:0] clr_thr,
   output logic             defect,
   output logic             toggle
);

   win_res_t set_res;
   win_res_t clr_res;
   logic     set_fire;
   logic     clr_fire;
   logic     restart;
   logic     defect_q;

   assign restart = set_fire || clr_fire;

   b2i_window_acc #(.ERR_W(ERR_W), .ACC_W(ACC_W), .WIN_W(WIN_W)) u_set_acc (
      .clk(clk), .rst(rst), .restart(restart), .frame_stb(frame_stb), .err(err),
      .cfg_winsz(set_winsz), .cfg_thr(set_thr), .res(set_res)
   );

   b2i_window_acc #(.ERR_W(ERR_W), .ACC_W(ACC_W), .WIN_W(WIN_W)) u_clr_acc (
      .clk(clk), .rst(rst), .restart(restart), .frame_stb(frame_stb), .err(err),
      .cfg_winsz(clr_winsz), .cfg_thr(clr_thr), .res(clr_res)
   );

   b2i_run_cnt #(.CNT_W(CNT_W)) u_set_run (
      .clk(clk), .rst(rst), .restart(restart), .arm(!defect_q),
      .step(set_res.done), .qual(set_res.over), .cfg_nwin(set_nwin), .fire(set_fire)
   );

   b2i_run_cnt #(.CNT_W(CNT_W)) u_clr_run (
      .clk(clk), .rst(rst), .restart(restart), .arm(defect_q),
      .step(clr_res.done), .qual(!clr_res.over), .cfg_nwin(clr_nwin), .fire(clr_fire)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         defect_q <= 1'b0;
         toggle   <= 1'b0;
      end else begin
         toggle <= restart;
         if (set_fire)      defect_q <= 1'b1;
         else if (clr_fire) defect_q <= 1'b0;
      end
   end

   assign defect = defect_q;

   // declaration only right after a failing declare-side window
   assert_rise_after_window_R3 : assert property (@(posedge clk) disable iff (rst)
      $rose(defect_q) |-> $past(set_res.done && set_res.over));

   // clearing only right after a clean clear-side window
   assert_fall_after_window_R5 : assert property (@(posedge clk) disable iff (rst)
      $fell(defect_q) |-> $past(clr_res.done && !clr_res.over));

endmodule

// File: rtl/b2_rate_defect_mon.sv
module b2_rate_defect_mon
   import b2i_pkg::*;
#(
   parameter int unsigned ERR_W = 16,
   parameter int unsigned ACC_W = 24,
   parameter int unsigned WIN_W = 16,
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             frame_stb,
   input  logic [ERR_W-1:0] b2_err,
   input  logic [WIN_W-1:0] exc_set_winsz,
   input  logic [CNT_W-1:0] exc_set_nwin,
   input  logic [ACC_W-1:0] exc_set_thr,
   input  logic [WIN_W-1:0] exc_clr_winsz,
   input  logic [CNT_W-1:0] exc_clr_nwin,
   input  logic [ACC_W-1:0] exc_clr_thr,
   input  logic [WIN_W-1:0] deg_set_winsz,
   input  logic [CNT_W-1:0] deg_set_nwin,
   input  logic [ACC_W-1:0] deg_set_thr,
   input  logic [WIN_W-1:0] deg_clr_winsz,
   input  logic [CNT_W-1:0] deg_clr_nwin,
   input  logic [ACC_W-1:0] deg_clr_thr,
   input  logic             en_ais,
   input  logic             en_sf,
   input  logic             en_rdi,
   output logic             exc_defect,
   output logic             deg_defect,
   output logic             chg_irq,
   output logic             req_ais,
   output logic             req_sf,
   output logic             req_rdi
);

   if (ERR_W < 1 || ACC_W < ERR_W) begin : g_chk_w
      $error("b2_rate_defect_mon: need 1 <= ERR_W <= ACC_W");
   end

   logic [WIN_W-1:0]   set_winsz_a [NUM_LVL];
   logic [CNT_W-1:0]   set_nwin_a  [NUM_LVL];
   logic [ACC_W-1:0]   set_thr_a   [NUM_LVL];
   logic [WIN_W-1:0]   clr_winsz_a [NUM_LVL];
   logic [CNT_W-1:0]   clr_nwin_a  [NUM_LVL];
   logic [ACC_W-1:0]   clr_thr_a   [NUM_LVL];
   logic [NUM_LVL-1:0] defect_a;
   logic [NUM_LVL-1:0] toggle_a;

   assign set_winsz_a[LVL_EXC] = exc_set_winsz;
   assign set_nwin_a[LVL_EXC]  = exc_set_nwin;
   assign set_thr_a[LVL_EXC]   = exc_set_thr;
   assign clr_winsz_a[LVL_EXC] = exc_clr_winsz;
   assign clr_nwin_a[LVL_EXC]  = exc_clr_nwin;
   assign clr_thr_a[LVL_EXC]   = exc_clr_thr;
   assign set_winsz_a[LVL_DEG] = deg_set_winsz;
   assign set_nwin_a[LVL_DEG]  = deg_set_nwin;
   assign set_thr_a[LVL_DEG]   = deg_set_thr;
   assign clr_winsz_a[LVL_DEG] = deg_clr_winsz;
   assign clr_nwin_a[LVL_DEG]  = deg_clr_nwin;
   assign clr_thr_a[LVL_DEG]   = deg_clr_thr;

   for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
      b2i_integrator #(.ERR_W(ERR_W), .ACC_W(ACC_W), .WIN_W(WIN_W), .CNT_W(CNT_W)) u_integ (
         .clk(clk), .rst(rst), .frame_stb(frame_stb), .err(b2_err),
         .set_winsz(set_winsz_a[g]), .set_nwin(set_nwin_a[g]), .set_thr(set_thr_a[g]),
         .clr_winsz(clr_winsz_a[g]), .clr_nwin(clr_nwin_a[g]), .clr_thr(clr_thr_a[g]),
         .defect(defect_a[g]), .toggle(toggle_a[g])
      );
   end

   assign exc_defect = defect_a[LVL_EXC];
   assign deg_defect = defect_a[LVL_DEG];
   assign chg_irq    = |toggle_a;
   assign req_ais    = defect_a[LVL_EXC] & en_ais;
   assign req_sf     = defect_a[LVL_EXC] & en_sf;
   assign req_rdi    = defect_a[LVL_EXC] & en_rdi;

   // interrupt only in the cycle after a defect changed
   assert_irq_on_change_R8 : assert property (@(posedge clk) disable iff (rst)
      chg_irq |-> ((exc_defect != $past(exc_defect)) || (deg_defect != $past(deg_defect))));

   // degraded-side activity never moves the action requests
   assert_req_isolated_R10 : assert property (@(posedge clk) disable iff (rst)
      ($stable(exc_defect) && $stable({en_ais, en_sf, en_rdi})) |-> $stable({req_ais, req_sf, req_rdi}));

endmodule

// File: tb/b2_rate_defect_mon_test.sv
module b2_rate_defect_mon_test;

   localparam int ERR_W = 16;
   localparam int ACC_W = 24;
   localparam int WIN_W = 16;
   localparam int CNT_W = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic frame_stb = 1'b0;
   logic [ERR_W-1:0] b2_err = '0;
   logic [WIN_W-1:0] exc_set_winsz, exc_clr_winsz, deg_set_winsz, deg_clr_winsz;
   logic [CNT_W-1:0] exc_set_nwin, exc_clr_nwin, deg_set_nwin, deg_clr_nwin;
   logic [ACC_W-1:0] exc_set_thr, exc_clr_thr, deg_set_thr, deg_clr_thr;
   logic en_ais, en_sf, en_rdi;
   logic exc_defect, deg_defect, chg_irq, req_ais, req_sf, req_rdi;

   int checks = 0;
   int failures = 0;
   int irq_seen = 0;
   int irq_base = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   b2_rate_defect_mon #(.ERR_W(ERR_W), .ACC_W(ACC_W), .WIN_W(WIN_W), .CNT_W(CNT_W)) uut (
      .clk(clk), .rst(rst), .frame_stb(frame_stb), .b2_err(b2_err),
      .exc_set_winsz(exc_set_winsz), .exc_set_nwin(exc_set_nwin), .exc_set_thr(exc_set_thr),
      .exc_clr_winsz(exc_clr_winsz), .exc_clr_nwin(exc_clr_nwin), .exc_clr_thr(exc_clr_thr),
      .deg_set_winsz(deg_set_winsz), .deg_set_nwin(deg_set_nwin), .deg_set_thr(deg_set_thr),
      .deg_clr_winsz(deg_clr_winsz), .deg_clr_nwin(deg_clr_nwin), .deg_clr_thr(deg_clr_thr),
      .en_ais(en_ais), .en_sf(en_sf), .en_rdi(en_rdi),
      .exc_defect(exc_defect), .deg_defect(deg_defect), .chg_irq(chg_irq),
      .req_ais(req_ais), .req_sf(req_sf), .req_rdi(req_rdi)
   );

   always @(negedge clk) if (!rst && chg_irq) irq_seen++;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_irq(input string req, input int exp_delta);
      check(req, irq_seen - irq_base, exp_delta);
      irq_base = irq_seen;
   endtask

   // n frames of the same error count, 4 cycles per frame
   task automatic frames(input int n, input int err);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         frame_stb = 1'b1;
         b2_err    = ERR_W'(err);
         @(negedge clk);
         frame_stb = 1'b0;
         b2_err    = '0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic t_reset;
      check("R1 exc_defect", exc_defect, 0);
      check("R1 deg_defect", deg_defect, 0);
      check("R1 irq", chg_irq, 0);
      check("R1 requests", {req_ais, req_sf, req_rdi}, 0);
   endtask

   task automatic t_declare;
      frames(4, 3);                          // sum 12: failing, run 1
      frames(3, 2); frames(1, 3);            // sum 9 < 10: run reset
      check("R2 below threshold", exc_defect, 0);
      frames(1, 10); frames(3, 0);           // sum 10 == threshold: run 1
      check("R4 run restarted", exc_defect, 0);
      frames(1, 10); frames(3, 0);           // run 2: declare
      check("R3 declared", exc_defect, 1);
      check_irq("R8 irq on declare", 1);
      check("R9 all requests", {req_ais, req_sf, req_rdi}, 7);
   endtask

   task automatic t_clear;
      frames(1, 5); frames(3, 0);            // 5 >= clear thr 3, below declare thr
      check("R5 hysteresis holds", exc_defect, 1);
      frames(4, 0);                          // clean, run 1
      frames(1, 3); frames(3, 0);            // equals clear thr: run reset
      check("R5 run reset", exc_defect, 1);
      frames(4, 0);
      check("R5 one clean window", exc_defect, 1);
      frames(4, 0);
      check("R5 cleared", exc_defect, 0);
      check_irq("R8 irq on clear", 1);
      check("R9 requests off", {req_ais, req_sf, req_rdi}, 0);
   endtask

   task automatic t_enables;
      en_ais = 1'b1; en_sf = 1'b0; en_rdi = 1'b1;
      frames(8, 3);
      check("R3 redeclared", exc_defect, 1);
      check("R9 ais+rdi", {req_ais, req_sf, req_rdi}, 5);
      en_ais = 1'b0; en_sf = 1'b1; en_rdi = 1'b0;
      @(negedge clk);
      check("R9 sf only", {req_ais, req_sf, req_rdi}, 2);
      check("R10 deg quiet", deg_defect, 0);
      frames(8, 0);
      check("R5 cleared again", exc_defect, 0);
      check_irq("R8 two pulses", 2);
      en_ais = 1'b1; en_sf = 1'b1; en_rdi = 1'b1;
   endtask

   task automatic t_boundary_cfg;
      frames(2, 0);
      exc_set_thr = 24'd1; exc_set_nwin = 8'd1;
      frames(2, 1);                          // judged vs old threshold 10
      check("R6 old settings kept", exc_defect, 0);
      frames(4, 1);                          // new threshold 1, run 1
      check("R6 new settings applied", exc_defect, 1);
      frames(8, 0);
      check("R6 cleared", exc_defect, 0);
      check_irq("R8 pair", 2);
   endtask

   task automatic t_zero_cfg;
      exc_set_winsz = '0; exc_set_nwin = '0;
      exc_clr_winsz = '0; exc_clr_nwin = '0;
      frames(4, 0);                          // close the 4-frame window
      check("R7 no declare on clean", exc_defect, 0);
      frames(1, 1);
      check("R7 single frame declares", exc_defect, 1);
      frames(1, 0);
      check("R7 single frame clears", exc_defect, 0);
      check_irq("R8 zero cfg pair", 2);
   endtask

   task automatic t_saturate;
      exc_set_winsz = 16'd300; exc_set_nwin = 8'd1; exc_set_thr = 24'hFFFFFF;
      exc_clr_winsz = 16'd1;   exc_clr_nwin = 8'd1;
      frames(1, 0);                          // boundary loads 300-frame window
      frames(299, 65535);
      check("R11 window not closed", exc_defect, 0);
      frames(1, 65535);
      check("R11 saturated sum fails", exc_defect, 1);
      frames(1, 0);
      check("R11 cleared", exc_defect, 0);
      check_irq("R8 sat pair", 2);
   endtask

   task automatic t_degraded;
      deg_set_thr = 24'd5;
      frames(4, 3);
      check("R10 deg declared", deg_defect, 1);
      check("R10 exc untouched", exc_defect, 0);
      check("R10 no requests", {req_ais, req_sf, req_rdi}, 0);
      frames(4, 0);
      check("R10 deg cleared", deg_defect, 0);
      check_irq("R8 deg pair", 2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      exc_set_winsz = 16'd4; exc_set_nwin = 8'd2; exc_set_thr = 24'd10;
      exc_clr_winsz = 16'd4; exc_clr_nwin = 8'd2; exc_clr_thr = 24'd3;
      deg_set_winsz = 16'd2; deg_set_nwin = 8'd1; deg_set_thr = 24'hFFFFFF;
      deg_clr_winsz = 16'd2; deg_clr_nwin = 8'd1; deg_clr_thr = 24'd1;
      en_ais = 1'b1; en_sf = 1'b1; en_rdi = 1'b1;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_declare();
      t_clear();
      t_enables();
      t_boundary_cfg();
      t_zero_cfg();
      t_saturate();
      t_degraded();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule